// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup

This block translates a (process id, virtual page number) pair into a physical frame number. It holds an inverted page table with exactly one entry per physical frame, so storage grows with physical memory and not with the virtual address space. Each entry records the owning process, the virtual page, a valid flag, a dirty (modify) flag and a link to the next entry of its collision chain. The frame number returned on a hit is the index of the entry that matched.

A lookup starts at the entry picked by the page number modulo 8. It walks the chain one entry per clock until it finds a valid entry whose page and process both match, until it reaches a link that marks the end of the chain, or until it has visited as many entries as the table holds. That last limit stops a corrupted circular chain from hanging the walker. A lookup flagged as a store sets the dirty flag of the entry it hits. Software installs entries and builds chains through a separate write port. It does not choose victims or refill the table on a miss.

Top module: `ipt_lookup`

## Requirements
- R1: After reset every entry is invalid with an end-of-chain link, `req_ready` is high and `rsp_valid` is low. A lookup then misses with its response one cycle after acceptance.
- R2: The walk starts at entry (`req_vpn` mod 8). When that entry matches, `rsp_valid` rises on the first clock edge after the edge that accepted the request.
- R3: An entry hits only when its valid flag is set and both its page number and process id equal the request. `rsp_frame` then gives that entry's index.
- R4: An entry that is invalid, or that differs in process id or page number, is not a hit. The walk continues through its link.
- R5: Each step along a chain takes one clock. A hit on the k-th entry visited gives its response k edges after the accepting edge.
- R6: A link with its top bit set (bit 3 at the default size, value 8 used for end of chain) ends the walk after the current entry, with `rsp_hit` low.
- R7: A walk that visits NFRAMES entries without a hit or end of chain gives up with a miss NFRAMES edges after acceptance.
- R8: A hit whose request had `req_write` high sets that entry's dirty flag. `rsp_modify` reports the flag as it was before the lookup. Read lookups leave it unchanged.
- R9: While a walk is in progress `req_ready` is low, and a request presented then is ignored.
- R10: A table write sets all fields of entry `wr_idx` on the next edge, including clearing or setting the dirty flag. The write replaces whatever that entry held before.
- R11: Each accepted request produces exactly one `rsp_valid` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request taken on this edge |
| req_pid | input | PID_W | Process id to look up |
| req_vpn | input | VPN_W | Virtual page number to look up |
| req_write | input | 1 | Lookup is for a store, mark dirty on hit |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_frame | output | IDX_W | Frame index of the hit (0 on miss) |
| rsp_modify | output | 1 | Dirty flag of hit entry before this lookup |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | IDX_W | Entry (frame) to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_modify | input | 1 | Dirty flag to store |
| wr_pid | input | PID_W | Process id to store |
| wr_vpn | input | VPN_W | Page number to store |
| wr_link | input | IDX_W+1 | Chain link, top bit set means end of chain |

## Verification
The bench builds a three-deep chain and measures response latency. A walker that skipped a hop, or that took an extra cycle per entry, would report the wrong frame or a response one cycle off. Entries that differ only in process id, or that are invalid in the middle of a chain, test whether the design wrongly stops or hits on a partial match. A two-entry circular chain tests the visit limit: a design that hangs, or that gives up one entry early or late, misses the response at exactly eight cycles. A request held high during a long walk, then store and load lookups on the same entry, expose a walker that accepts mid-search or a dirty flag that is never set or is reported after its update.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic {
    WALK_IDLE   = 1'b0,
    WALK_SEARCH = 1'b1
  } walk_state_t;

  // number of bits needed to index n items (at least 1)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int unsigned VPN_W    = 20,
  parameter int unsigned HASH_MOD = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] home_idx
);

  localparam int unsigned MOD_BITS = ipt_pkg::idx_bits(HASH_MOD);
  localparam bit          MOD_POW2 = ((1 << MOD_BITS) == HASH_MOD);

  generate
    if (MOD_POW2) begin : g_slice
      // power-of-two modulus: low bits of the page number
      logic [MOD_BITS-1:0] low_bits;
      assign low_bits = vpn[MOD_BITS-1:0];
      assign home_idx = IDX_W'(low_bits);
    end else begin : g_div
      logic [VPN_W-1:0] rem;
      assign rem      = vpn % VPN_W'(HASH_MOD);
      assign home_idx = rem[IDX_W-1:0];
    end
  endgenerate

  always_comb begin
    assert_home_in_range_R2: assert (int'(home_idx) < int'(HASH_MOD) || $isunknown(vpn));
  end

endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int unsigned NFRAMES = 8,
  parameter int unsigned PID_W   = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned LINK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  // software install port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_modify,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [LINK_W-1:0] wr_link,
  // dirty-flag set from the walker
  input  logic              mark_en,
  input  logic [IDX_W-1:0]  mark_idx,
  // probe read port
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_modify,
  output logic [PID_W-1:0]  rd_pid,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [LINK_W-1:0] rd_link
);

  localparam logic [LINK_W-1:0] LINK_END = LINK_W'(1) << (LINK_W - 1);

  // key storage: no reset, plain memory style
  logic [PID_W-1:0] pid_mem [NFRAMES];
  logic [VPN_W-1:0] vpn_mem [NFRAMES];

  // control storage: reset per entry
  logic              valid_q  [NFRAMES];
  logic              modify_q [NFRAMES];
  logic [LINK_W-1:0] link_q   [NFRAMES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pid_mem[wr_idx] <= wr_pid;
      vpn_mem[wr_idx] <= wr_vpn;
    end
  end

  generate
    for (genvar e = 0; e < NFRAMES; e++) begin : g_entry
      logic sel_wr;
      logic sel_mark;
      assign sel_wr   = wr_en   && (wr_idx   == IDX_W'(e));
      assign sel_mark = mark_en && (mark_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[e]  <= 1'b0;
          modify_q[e] <= 1'b0;
          link_q[e]   <= LINK_END;
        end else if (sel_wr) begin
          // software install takes priority over a dirty mark
          valid_q[e]  <= wr_valid;
          modify_q[e] <= wr_modify;
          link_q[e]   <= wr_link;
        end else if (sel_mark) begin
          modify_q[e] <= 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_valid  = 1'b0;
    rd_modify = 1'b0;
    rd_link   = LINK_END;
    rd_pid    = '0;
    rd_vpn    = '0;
    if (int'(rd_idx) < int'(NFRAMES)) begin
      rd_valid  = valid_q[rd_idx];
      rd_modify = modify_q[rd_idx];
      rd_link   = link_q[rd_idx];
      rd_pid    = pid_mem[rd_idx];
      rd_vpn    = vpn_mem[rd_idx];
    end
  end

  // install lands on the next edge
  assert_install_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid)) &&
              (link_q[$past(wr_idx)]  == $past(wr_link)));

  // a dirty mark not overridden by an install sticks
  assert_mark_sets_dirty_R8: assert property (@(posedge clk) disable iff (rst)
    (mark_en && !(wr_en && wr_idx == mark_idx)) |=> modify_q[$past(mark_idx)]);

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int unsigned NFRAMES  = 8,
  parameter int unsigned PID_W    = 4,
  parameter int unsigned VPN_W    = 20,
  parameter int unsigned HASH_MOD = 8,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned LINK_W   = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  home_idx,
  // probe into the table
  output logic [IDX_W-1:0]  probe_idx,
  input  logic              ent_valid,
  input  logic              ent_modify,
  input  logic [PID_W-1:0]  ent_pid,
  input  logic [VPN_W-1:0]  ent_vpn,
  input  logic [LINK_W-1:0] ent_link,
  output logic              mark_en,
  output logic [IDX_W-1:0]  mark_idx,
  // response
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic              rsp_modify
);

  import ipt_pkg::*;

  localparam bit                FRAMES_POW2 = ((1 << IDX_W) == NFRAMES);
  localparam logic [CNT_W-1:0]  LAST_HOP    = CNT_W'(NFRAMES - 1);

  walk_state_t      state_q;
  logic [PID_W-1:0] key_pid_q;
  logic [VPN_W-1:0] key_vpn_q;
  logic             key_wr_q;
  logic [IDX_W-1:0] cur_q;
  logic [CNT_W-1:0] hops_q;

  logic             searching;
  logic             match;
  logic             chain_end;
  logic             give_up;
  logic [IDX_W-1:0] next_idx;

  assign searching = (state_q == WALK_SEARCH);
  assign req_ready = (state_q == WALK_IDLE);
  assign probe_idx = cur_q;
  assign next_idx  = ent_link[IDX_W-1:0];

  generate
    if (FRAMES_POW2) begin : g_end_bit
      assign chain_end = ent_link[LINK_W-1];
    end else begin : g_end_range
      // links past the last frame also end the chain
      assign chain_end = ent_link[LINK_W-1] || (int'(next_idx) >= int'(NFRAMES));
    end
  endgenerate

  always_comb begin
    match   = searching && ent_valid &&
              (ent_pid == key_pid_q) && (ent_vpn == key_vpn_q);
    give_up = searching && !match && (chain_end || (hops_q == LAST_HOP));
  end

  assign mark_en  = match && key_wr_q;
  assign mark_idx = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= WALK_IDLE;
      key_pid_q  <= '0;
      key_vpn_q  <= '0;
      key_wr_q   <= 1'b0;
      cur_q      <= '0;
      hops_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_frame  <= '0;
      rsp_modify <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        WALK_IDLE: begin
          if (req_valid) begin
            key_pid_q <= req_pid;
            key_vpn_q <= req_vpn;
            key_wr_q  <= req_write;
            cur_q     <= home_idx;
            hops_q    <= '0;
            state_q   <= WALK_SEARCH;
          end
        end
        WALK_SEARCH: begin
          if (match) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            rsp_frame  <= cur_q;
            rsp_modify <= ent_modify;
            state_q    <= WALK_IDLE;
          end else if (give_up) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_frame  <= '0;
            rsp_modify <= 1'b0;
            state_q    <= WALK_IDLE;
          end else begin
            cur_q  <= next_idx;
            hops_q <= hops_q + CNT_W'(1);
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  // walk begins at page number modulo HASH_MOD
  assert_home_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=>
      (cur_q == IDX_W'($past(req_vpn) % VPN_W'(HASH_MOD))) && (hops_q == '0));

  // a taken request closes the door until the walk ends
  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // the visit counter never passes the table size
  assert_hop_bound_R7: assert property (@(posedge clk) disable iff (rst)
    searching |-> (hops_q <= LAST_HOP));

  // responses only come out of a walk
  assert_rsp_from_walk_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(searching));

  // end-of-chain link without a match reports a miss
  assert_end_link_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (searching && !match && chain_end) |=> (rsp_valid && !rsp_hit));

  // reported frame is a real frame
  assert_frame_range_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (int'(rsp_frame) < int'(NFRAMES)));

endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup #(
  parameter int unsigned NFRAMES  = 8,
  parameter int unsigned PID_W    = 4,
  parameter int unsigned VPN_W    = 20,
  parameter int unsigned HASH_MOD = 8,
  localparam int unsigned IDX_W   = ipt_pkg::idx_bits(NFRAMES),
  localparam int unsigned LINK_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_frame,
  output logic              rsp_modify,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_modify,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [LINK_W-1:0] wr_link
);

  localparam int unsigned CNT_W = ipt_pkg::idx_bits(NFRAMES + 1);

  initial begin
    assert_hash_fits_R2: assert (HASH_MOD >= 1 && HASH_MOD <= NFRAMES);
  end

  logic [IDX_W-1:0]  home_idx;
  logic [IDX_W-1:0]  probe_idx;
  logic              ent_valid;
  logic              ent_modify;
  logic [PID_W-1:0]  ent_pid;
  logic [VPN_W-1:0]  ent_vpn;
  logic [LINK_W-1:0] ent_link;
  logic              mark_en;
  logic [IDX_W-1:0]  mark_idx;

  ipt_hash #(
    .VPN_W(VPN_W), .HASH_MOD(HASH_MOD), .IDX_W(IDX_W)
  ) u_hash (
    .vpn      (req_vpn),
    .home_idx (home_idx)
  );

  ipt_table #(
    .NFRAMES(NFRAMES), .PID_W(PID_W), .VPN_W(VPN_W),
    .IDX_W(IDX_W), .LINK_W(LINK_W)
  ) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_modify (wr_modify),
    .wr_pid    (wr_pid),
    .wr_vpn    (wr_vpn),
    .wr_link   (wr_link),
    .mark_en   (mark_en),
    .mark_idx  (mark_idx),
    .rd_idx    (probe_idx),
    .rd_valid  (ent_valid),
    .rd_modify (ent_modify),
    .rd_pid    (ent_pid),
    .rd_vpn    (ent_vpn),
    .rd_link   (ent_link)
  );

  ipt_walker #(
    .NFRAMES(NFRAMES), .PID_W(PID_W), .VPN_W(VPN_W), .HASH_MOD(HASH_MOD),
    .IDX_W(IDX_W), .LINK_W(LINK_W), .CNT_W(CNT_W)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pid    (req_pid),
    .req_vpn    (req_vpn),
    .req_write  (req_write),
    .home_idx   (home_idx),
    .probe_idx  (probe_idx),
    .ent_valid  (ent_valid),
    .ent_modify (ent_modify),
    .ent_pid    (ent_pid),
    .ent_vpn    (ent_vpn),
    .ent_link   (ent_link),
    .mark_en    (mark_en),
    .mark_idx   (mark_idx),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_frame  (rsp_frame),
    .rsp_modify (rsp_modify)
  );

endmodule

// File: tb/sim_ipt_lookup.sv
module sim_ipt_lookup;

  localparam int unsigned PID_W = 4;
  localparam int unsigned VPN_W = 20;
  localparam int unsigned IDX_W = 3;
  localparam logic [3:0]  LEND  = 4'h8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [PID_W-1:0] req_pid = '0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             req_write = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_modify;
  logic [IDX_W-1:0] rsp_frame;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic             wr_valid = 1'b0, wr_modify = 1'b0;
  logic [PID_W-1:0] wr_pid = '0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [3:0]       wr_link = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ipt_lookup u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_pid(req_pid),
    .req_vpn(req_vpn), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_frame(rsp_frame),
    .rsp_modify(rsp_modify),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_modify(wr_modify),
    .wr_pid(wr_pid), .wr_vpn(wr_vpn), .wr_link(wr_link)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic install(input int idx, input bit v, input bit m,
                         input int pid, input int vpn, input logic [3:0] link);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v; wr_modify = m;
    wr_pid = PID_W'(pid); wr_vpn = VPN_W'(vpn); wr_link = link;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // issue one lookup and check hit, frame, latency, dirty and pulse width
  task automatic lookup(input string req, input int pid, input int vpn, input bit wr,
                        input bit exp_hit, input int exp_frame, input int exp_lat,
                        input int exp_mod);
    int lat = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pid = PID_W'(pid); req_vpn = VPN_W'(vpn); req_write = wr;
    check(req, "ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (rsp_valid) begin lat = n; break; end
    end
    check(req, "latency", lat, exp_lat);
    check(req, "hit", int'(rsp_hit), int'(exp_hit));
    if (exp_hit) check(req, "frame", int'(rsp_frame), exp_frame);
    if (exp_mod >= 0) check(req, "dirty", int'(rsp_modify), exp_mod);
    @(negedge clk);
    check("R11", "pulse width", int'(rsp_valid), 0);
  endtask

  task automatic t_reset;
    check("R1", "ready after reset", int'(req_ready), 1);
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    lookup("R1", 0, 'h5, 0, 0, 0, 1, -1);
  endtask

  task automatic t_home_hit;
    install(3, 1, 0, 2, 'h00013, LEND);
    install(5, 1, 0, 9, 'hABCD5, LEND);
    lookup("R2", 2, 'h00013, 0, 1, 3, 1, 0);
    lookup("R2", 9, 'hABCD5, 0, 1, 5, 1, 0);
    lookup("R3", 2, 'hFFFF3, 0, 0, 0, 1, -1);
  endtask

  task automatic t_mismatch;
    lookup("R4", 5, 'h00013, 0, 0, 0, 1, -1);
    lookup("R4", 2, 'h0000B, 0, 0, 0, 1, -1);
  endtask

  task automatic t_chain;
    install(1, 1, 0, 1, 'h00011, 4'h6);
    install(6, 1, 0, 1, 'h00021, 4'h4);
    install(4, 1, 0, 1, 'h00031, LEND);
    lookup("R5", 1, 'h00011, 0, 1, 1, 1, 0);
    lookup("R5", 1, 'h00021, 0, 1, 6, 2, 0);
    lookup("R5", 1, 'h00031, 0, 1, 4, 3, 0);
    lookup("R6", 1, 'h00041, 0, 0, 0, 3, -1);
    // invalidate the middle entry but keep its link
    install(6, 0, 0, 1, 'h00021, 4'h4);
    lookup("R4", 1, 'h00021, 0, 0, 0, 3, -1);
    lookup("R4", 1, 'h00031, 0, 1, 4, 3, 0);
  endtask

  task automatic t_dirty;
    lookup("R8", 2, 'h00013, 1, 1, 3, 1, 0);
    lookup("R8", 2, 'h00013, 0, 1, 3, 1, 1);
    lookup("R8", 1, 'h00031, 0, 1, 4, 3, 0);
    lookup("R8", 1, 'h00031, 0, 1, 4, 3, 0);
    install(3, 1, 0, 2, 'h00013, LEND);
    lookup("R10", 2, 'h00013, 0, 1, 3, 1, 0);
    install(4, 1, 0, 1, 'h00077, LEND);
    lookup("R10", 1, 'h00031, 0, 0, 0, 3, -1);
  endtask

  task automatic t_loop_and_busy;
    int lat = 0;
    int pulses = 0;
    install(0, 1, 0, 3, 'h00010, 4'h7);
    install(7, 1, 0, 3, 'h00050, 4'h0);
    lookup("R7", 3, 'h00008, 0, 0, 0, 8, -1);
    // second run: hold a hitting request high while the walk runs
    @(negedge clk);
    req_valid = 1'b1; req_pid = 4'd3; req_vpn = 20'h00008;
    @(negedge clk);
    req_pid = 4'd2; req_vpn = 20'h00013;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      check("R9", "ready during walk", int'(req_ready), 0);
      if (rsp_valid) pulses++;
    end
    req_valid = 1'b0;
    for (int n = 6; n <= 14; n++) begin
      @(negedge clk);
      if (rsp_valid) begin
        pulses++;
        if (lat == 0) begin
          lat = n;
          check("R9", "held request ignored, miss", int'(rsp_hit), 0);
        end
      end
    end
    check("R7", "loop give-up latency", lat, 8);
    check("R11", "one pulse per request", pulses, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_home_hit();
    t_mismatch();
    t_chain();
    t_dirty();
    t_loop_and_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule